// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns the destination fields of one interrupt routing entry into a bitmask of target local interrupt controllers. Up to `N_TGT` targets can be registered. Each target carries an 8-bit physical ID, an 8-bit logical group byte and a 4-bit destination format nibble. Targets are registered one at a time in strictly rising index order. A request carries an 8-bit destination, a destination mode bit and a 3-bit delivery mode. One cycle later the block returns a registered target mask together with status flags.

In physical mode the lowest-indexed registered target whose ID equals the destination is selected. In logical mode each registered target is matched under its own format: flat or cluster. Fixed and external delivery pass every match through. Lowest-priority delivery keeps exactly one match, chosen by a rotating pointer. Any other delivery mode is refused. Choosing priority among targets and injecting the vector are left to the blocks downstream.

Top module: `idr_resolver`

## Requirements
- R1: After reset, `res_valid` and `reg_err` are 0, no target is registered and the rotating pointer is 0.
- R2: A registration is accepted only when `reg_index` equals the current count and the count is below `N_TGT`. An accepted registration stores the target and raises the count by one. Any other registration changes nothing and pulses `reg_err` high for one cycle, one cycle after the attempt.
- R3: Only targets whose index is below the registered count can appear in the mask or cause a format error.
- R4: In physical mode (`req_dest_mode`=0), the mask holds only the lowest-indexed registered target whose ID equals `req_dest`.
- R5: In logical mode (`req_dest_mode`=1), a destination of 0 matches no target.
- R6: A target with format nibble 4'hF (flat) matches when `req_dest` AND its group byte is nonzero.
- R7: A target with format nibble 4'h0 (cluster) matches when group bits [7:4] equal `req_dest`[7:4] and group bits [3:0] AND `req_dest`[3:0] is nonzero.
- R8: A registered target with any other format nibble never matches. If it is evaluated in logical mode with a nonzero destination, `res_fmt_err` is set.
- R9: Delivery modes fixed (3'b000) and external (3'b111) return every match.
- R10: Lowest-priority mode (3'b001) returns only the first match at or after the pointer, wrapping past the top index to 0. When a target is chosen, the pointer moves to the chosen index plus one, modulo `N_TGT`. When the match set is empty, the pointer does not move.
- R11: Delivery modes 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110 return an empty mask and set `res_unsupported`.
- R12: `res_no_target` is 1 exactly when the returned mask is empty. No delivery takes place then.
- R13: Each request cycle yields a `res_valid` pulse one cycle later, and requests may come in back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Registration strobe |
| reg_index | input | IW | Index of the target being registered |
| reg_id | input | 8 | Physical ID of the target |
| reg_lgrp | input | 8 | Logical group byte (logical register bits 31:24) |
| reg_fmt | input | 4 | Format nibble (format register bits 31:28) |
| reg_err | output | 1 | Registration refused (out of order or table full) |
| req_valid | input | 1 | Resolution request strobe |
| req_dest | input | 8 | Destination value |
| req_dest_mode | input | 1 | 0 physical, 1 logical |
| req_deliv | input | 3 | Delivery mode code |
| res_valid | output | 1 | Result strobe |
| res_mask | output | N_TGT | Target mask |
| res_no_target | output | 1 | Mask is empty |
| res_unsupported | output | 1 | Delivery mode refused |
| res_fmt_err | output | 1 | A registered target has an invalid format |

## Verification
The assertions assume that the input fields are defined whenever `req_valid` or `reg_valid` is high. They also assume that a request resolves against the target count held before that edge. The range check is therefore written against the previous count. The stimulus first fills the table, including refused registrations, and only then issues requests, so no registration and request share a cycle. The lowest-priority bursts run back to back, so each pointer update is seen by the very next request.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int DEST_W = 8;
  localparam int GRP_W  = 8;
  localparam int FMT_W  = 4;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_EXT    = 3'b111
  } deliv_e;

  localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

  typedef struct packed {
    logic [DEST_W-1:0] id;
    logic [GRP_W-1:0]  grp;
    logic [FMT_W-1:0]  fmt;
  } tgt_t;
endpackage

// File: rtl/idr_target_table.sv
module idr_target_table
  import idr_pkg::*;
#(
  parameter int N_TGT = 32,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int CW = $clog2(N_TGT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [IW-1:0]         wr_index,
  input  tgt_t                  wr_entry,
  output logic                  wr_err,
  output tgt_t [N_TGT-1:0]      tbl_q,
  output logic [CW-1:0]         count_q
);
  logic accept;

  assign accept = wr_valid && (CW'(wr_index) == count_q) && (count_q < CW'(N_TGT));

  // entries carry no reset: an entry above the count is never consulted
  always_ff @(posedge clk) begin
    if (accept) tbl_q[wr_index] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= wr_valid && !accept;
      if (accept) count_q <= count_q + CW'(1);
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1)));

  a_r2_refused_keeps_count: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> count_q == $past(count_q));
endmodule

// File: rtl/idr_match_array.sv
module idr_match_array
  import idr_pkg::*;
#(
  parameter int N_TGT = 32,
  localparam int CW = $clog2(N_TGT + 1)
) (
  input  tgt_t [N_TGT-1:0]  tbl,
  input  logic [CW-1:0]     count,
  input  logic [DEST_W-1:0] dest,
  input  logic              logical,
  output logic [N_TGT-1:0]  cand,
  output logic              fmt_err
);
  logic [N_TGT-1:0] live, id_eq, log_hit, bad_fmt;
  logic             dest_nz;

  assign dest_nz = |dest;

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    logic is_flat, is_clu, flat_hit, clu_hit;
    assign live[g]    = (CW'(g) < count);
    assign is_flat    = (tbl[g].fmt == FMT_FLAT);
    assign is_clu     = (tbl[g].fmt == FMT_CLUSTER);
    assign flat_hit   = |(tbl[g].grp & dest);
    assign clu_hit    = (tbl[g].grp[7:4] == dest[7:4]) && (|(tbl[g].grp[3:0] & dest[3:0]));
    assign id_eq[g]   = live[g] && (tbl[g].id == dest);
    assign log_hit[g] = live[g] && dest_nz && ((is_flat && flat_hit) || (is_clu && clu_hit));
    assign bad_fmt[g] = live[g] && dest_nz && !is_flat && !is_clu;
  end

  // physical: keep only the lowest matching index
  logic [N_TGT-1:0] phys_first;
  always_comb begin
    logic seen;
    phys_first = '0;
    seen = 1'b0;
    for (int k = 0; k < N_TGT; k++) begin
      if (id_eq[k] && !seen) begin
        phys_first[k] = 1'b1;
        seen = 1'b1;
      end
    end
  end

  assign cand    = logical ? log_hit : phys_first;
  assign fmt_err = logical && (|bad_fmt);
endmodule

// File: rtl/idr_rr_pick.sv
module idr_rr_pick #(
  parameter int N_TGT = 32,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [N_TGT-1:0] req,
  input  logic [IW-1:0]    ptr,
  output logic [N_TGT-1:0] grant,
  output logic [IW-1:0]    grant_idx
);
  always_comb begin
    logic got;
    grant     = '0;
    grant_idx = '0;
    got       = 1'b0;
    for (int k = 0; k < N_TGT; k++) begin
      if (!got && req[k] && (k >= int'(ptr))) begin
        grant[k]  = 1'b1;
        grant_idx = IW'(k);
        got       = 1'b1;
      end
    end
    for (int k = 0; k < N_TGT; k++) begin
      if (!got && req[k]) begin
        grant[k]  = 1'b1;
        grant_idx = IW'(k);
        got       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/idr_resolver.sv
module idr_resolver
  import idr_pkg::*;
#(
  parameter int N_TGT = 32,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int CW = $clog2(N_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic [IW-1:0]     reg_index,
  input  logic [7:0]        reg_id,
  input  logic [7:0]        reg_lgrp,
  input  logic [3:0]        reg_fmt,
  output logic              reg_err,
  input  logic              req_valid,
  input  logic [7:0]        req_dest,
  input  logic              req_dest_mode,
  input  logic [2:0]        req_deliv,
  output logic              res_valid,
  output logic [N_TGT-1:0]  res_mask,
  output logic              res_no_target,
  output logic              res_unsupported,
  output logic              res_fmt_err
);
  tgt_t [N_TGT-1:0] tbl;
  tgt_t             wr_entry;
  logic [CW-1:0]    tgt_cnt;
  logic [N_TGT-1:0] cand, grant, mask_d;
  logic             fmt_err_d, unsup_d, lp_sel;
  logic [IW-1:0]    rr_ptr, grant_idx;

  assign wr_entry = '{id: reg_id, grp: reg_lgrp, fmt: reg_fmt};

  idr_target_table #(.N_TGT(N_TGT)) u_table (
    .clk(clk), .rst(rst),
    .wr_valid(reg_valid), .wr_index(reg_index), .wr_entry(wr_entry),
    .wr_err(reg_err), .tbl_q(tbl), .count_q(tgt_cnt)
  );

  idr_match_array #(.N_TGT(N_TGT)) u_match (
    .tbl(tbl), .count(tgt_cnt), .dest(req_dest), .logical(req_dest_mode),
    .cand(cand), .fmt_err(fmt_err_d)
  );

  idr_rr_pick #(.N_TGT(N_TGT)) u_rr (
    .req(cand), .ptr(rr_ptr), .grant(grant), .grant_idx(grant_idx)
  );

  always_comb begin
    mask_d  = '0;
    unsup_d = 1'b0;
    lp_sel  = 1'b0;
    case (deliv_e'(req_deliv))
      DM_FIXED, DM_EXT: mask_d = cand;
      DM_LOWPRI: begin
        mask_d = grant;
        lp_sel = 1'b1;
      end
      default: unsup_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (req_valid && lp_sel && (|cand)) begin
      rr_ptr <= (int'(grant_idx) == N_TGT - 1) ? '0 : grant_idx + IW'(1);
    end
  end

  logic res_phys, res_lp;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid       <= 1'b0;
      res_mask        <= '0;
      res_no_target   <= 1'b0;
      res_unsupported <= 1'b0;
      res_fmt_err     <= 1'b0;
      res_phys        <= 1'b0;
      res_lp          <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_mask        <= mask_d;
        res_no_target   <= ~(|mask_d);
        res_unsupported <= unsup_d;
        res_fmt_err     <= fmt_err_d;
        res_phys        <= !req_dest_mode;
        res_lp          <= lp_sel;
      end
    end
  end

  a_r4_phys_single: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_phys |-> $onehot0(res_mask));

  a_r10_lowpri_single: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_lp |-> $onehot0(res_mask));

  a_r11_refused_empty: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_unsupported |-> (res_mask == '0) && res_no_target);

  a_r3_within_count: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_mask >> $past(tgt_cnt)) == '0));

  a_r13_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  a_r13_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
endmodule

// File: tb/idr_resolver_tb.sv
module idr_resolver_tb_top;
  localparam int N  = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_valid = 1'b0;
  logic [IW-1:0] reg_index = '0;
  logic [7:0]    reg_id = '0, reg_lgrp = '0;
  logic [3:0]    reg_fmt = '0;
  logic          reg_err;
  logic          req_valid = 1'b0;
  logic [7:0]    req_dest = '0;
  logic          req_dest_mode = 1'b0;
  logic [2:0]    req_deliv = '0;
  logic          res_valid, res_no_target, res_unsupported, res_fmt_err;
  logic [N-1:0]  res_mask;

  always #4 clk = ~clk;

  idr_resolver #(.N_TGT(N)) dut_i (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_index(reg_index), .reg_id(reg_id),
    .reg_lgrp(reg_lgrp), .reg_fmt(reg_fmt), .reg_err(reg_err),
    .req_valid(req_valid), .req_dest(req_dest), .req_dest_mode(req_dest_mode),
    .req_deliv(req_deliv), .res_valid(res_valid), .res_mask(res_mask),
    .res_no_target(res_no_target), .res_unsupported(res_unsupported),
    .res_fmt_err(res_fmt_err)
  );

  typedef struct {
    logic [N-1:0] mask;
    logic         nt, un, fe;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // requirement-level model
  logic [7:0] m_id[N], m_grp[N];
  logic [3:0] m_fmt[N];
  int         m_cnt = 0, m_ptr = 0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic register(input int idx, input logic [7:0] id, input logic [7:0] grp,
                          input logic [3:0] fmt, input string tag);
    bit ok;
    ok = (idx == m_cnt) && (m_cnt < N);
    @(negedge clk);
    reg_valid = 1'b1; reg_index = IW'(idx); reg_id = id; reg_lgrp = grp; reg_fmt = fmt;
    @(negedge clk);
    reg_valid = 1'b0;
    check(reg_err == !ok, tag, $sformatf("%0b", reg_err), $sformatf("%0b", !ok));
    if (ok) begin
      m_id[idx] = id; m_grp[idx] = grp; m_fmt[idx] = fmt; m_cnt++;
    end
  endtask

  task automatic send(input logic [7:0] dest, input logic lmode, input logic [2:0] dm,
                      input string tag);
    exp_t e;
    logic [N-1:0] cand;
    bit seen;
    cand = '0; e.fe = 1'b0; seen = 0;
    for (int i = 0; i < m_cnt; i++) begin
      if (!lmode) begin
        if (!seen && m_id[i] == dest) begin cand[i] = 1'b1; seen = 1; end
      end else if (dest != 8'h00) begin
        if (m_fmt[i] == 4'hF) cand[i] = (m_grp[i] & dest) != 0;
        else if (m_fmt[i] == 4'h0)
          cand[i] = (m_grp[i][7:4] == dest[7:4]) && ((m_grp[i][3:0] & dest[3:0]) != 0);
        else e.fe = 1'b1;
      end
    end
    e.un = 1'b0; e.mask = '0;
    if (dm == 3'b000 || dm == 3'b111) e.mask = cand;
    else if (dm == 3'b001) begin
      for (int s = 0; s < N; s++) begin
        int j;
        j = (m_ptr + s) % N;
        if (e.mask == '0 && cand[j]) begin
          e.mask[j] = 1'b1;
          m_ptr = (j + 1) % N;
        end
      end
    end else e.un = 1'b1;
    e.nt = (e.mask == '0);
    e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_dest = dest; req_dest_mode = lmode; req_deliv = dm;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected result", "res_valid=1", "none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_mask == e.mask && res_no_target == e.nt && res_unsupported == e.un &&
              res_fmt_err == e.fe, e.tag,
              $sformatf("mask=%h nt=%0b un=%0b fe=%0b", res_mask, res_no_target, res_unsupported, res_fmt_err),
              $sformatf("mask=%h nt=%0b un=%0b fe=%0b", e.mask, e.nt, e.un, e.fe));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && reg_err == 1'b0, "R1 reset outputs",
          $sformatf("v=%0b e=%0b", res_valid, reg_err), "v=0 e=0");

    register(0, 8'd3,  8'h01, 4'hF, "R2 reg 0");
    register(1, 8'd5,  8'h02, 4'hF, "R2 reg 1");
    register(2, 8'd3,  8'h04, 4'hF, "R2 reg 2");
    register(3, 8'd9,  8'h21, 4'h0, "R2 reg 3");
    register(4, 8'd10, 8'h23, 4'h0, "R2 reg 4");
    register(5, 8'd11, 8'h01, 4'h8, "R2 reg 5");
    register(7, 8'd66, 8'hFF, 4'hF, "R2 skip ahead refused");
    register(2, 8'd66, 8'hFF, 4'hF, "R2 repeat index refused");

    send(8'd66, 1'b0, 3'b000, "R2 refused entry absent");
    send(8'd3,  1'b0, 3'b000, "R4 first of duplicate IDs");
    send(8'd5,  1'b0, 3'b000, "R4 single ID");
    send(8'd0,  1'b0, 3'b000, "R3 unregistered slots ignored");
    send(8'h77, 1'b0, 3'b000, "R12 physical no match");
    send(8'h00, 1'b1, 3'b000, "R5 logical zero");
    send(8'h03, 1'b1, 3'b000, "R6 R8 flat hits with bad format");
    send(8'h21, 1'b1, 3'b000, "R7 cluster and flat");
    send(8'h22, 1'b1, 3'b000, "R7 cluster bit select");
    send(8'h03, 1'b1, 3'b111, "R9 external passes all");
    idle(3);

    send(8'h21, 1'b1, 3'b001, "R10 lowpri from 0");
    send(8'h21, 1'b1, 3'b001, "R10 lowpri next");
    send(8'h21, 1'b1, 3'b001, "R10 lowpri next again");
    send(8'h40, 1'b1, 3'b001, "R10 R12 empty keeps pointer");
    send(8'h21, 1'b1, 3'b001, "R10 lowpri wraps");
    send(8'd3,  1'b0, 3'b001, "R10 lowpri physical");
    idle(2);

    send(8'h03, 1'b1, 3'b010, "R11 mode 010");
    send(8'h03, 1'b1, 3'b011, "R11 mode 011");
    send(8'd5,  1'b0, 3'b100, "R11 mode 100");
    send(8'd5,  1'b0, 3'b101, "R11 mode 101");
    send(8'd5,  1'b0, 3'b110, "R11 mode 110");
    idle(4);

    check(exp_q.size() == 0, "R13 all results seen", $sformatf("%0d", exp_q.size()), "0");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule